// File: doc/BRIEF.md
# DAC Conversion Sequencing Controller

This block is the digital control core for one digital-to-analog channel. Software reaches it over a simple read/write register bus. Each conversion starts in one of two ways. When the event-trigger mode is off, a write to the holding register starts it. When that mode is on, a pulse on an external trigger input or a write to the software-trigger register starts it. At the start of a conversion the block turns the holding word into a 12-bit code and latches it into the read-only output register. It then keeps the channel busy for a programmable number of settling cycles.

When the settling interval ends, the block raises a finish flag, which can drive the interrupt line. In DMA mode the block pulses a request after every load. If the next start arrives before fresh data has been written, the block records an under-run and reuses the previous data. The only trace of the analog side is the registered 12-bit code on `dac_code`.

Register decode: 0x00 control, 0x04 software trigger, 0x08 holding data, 0x0C output code, 0x10 status, 0x14 settling time.

Top module: `dacseq_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0, and `busy`, `irq`, `dma_req` and `dac_code` are all 0.
- R2: With the enable bit set and trigger mode off, a write to 0x08 starts a conversion. The output code (0x0C and `dac_code`) changes only when a conversion starts, and a bus write to 0x0C has no effect.
- R3: A conversion keeps `busy` (also status bit 8) high for exactly SETTLE+1 clock cycles. SETTLE is bits [9:0] of 0x14. The finish flag (status bit 0) is set when `busy` falls.
- R4: With trigger mode on (control bit 4), a conversion starts from a one-cycle pulse on `trig_in` or from writing 1 to bit 0 of 0x04. Holding writes, and writes of 0 to 0x04, start nothing. 0x04 always reads 0.
- R5: A start request is ignored, not deferred, if it arrives while `busy` is high or while the enable bit (control bit 0) is 0.
- R6: Code formatting uses control bits [15:14] (00 = 12-bit, 01 = 8-bit) and bit 10 (1 = left-aligned). The 12-bit code is taken from holding bits [11:0] when right-aligned and from bits [15:4] when left-aligned. In 8-bit mode the byte comes from bits [7:0] when right-aligned and from bits [15:8] when left-aligned, and it becomes code bits [11:4] with bits [3:0] set to 0.
- R7: The finish flag is cleared when a new conversion starts, and also by writing 1 to status bit 0.
- R8: `irq` = (finish AND control bit 1) OR (under-run flag AND control bit 3).
- R9: When DMA mode (control bit 2) is on, `dma_req` is high for exactly one cycle, in the cycle after each load.
- R10: In DMA mode, a load that has no holding write since the previous load (or since reset) sets the under-run flag (status bit 1) and reuses the old data. Writing 1 to status bit 1 clears the flag. With DMA mode off, the flag is never set.
- R11: Control bits 0–4, 10 and 15:14 read back as written, and all other control bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| trig_in | input | 1 | Start pulse from the trigger unit |
| dac_code | output | 12 | Registered code to the converter |
| busy | output | 1 | Conversion in progress |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | One-cycle request for the next data word |

## Verification
A wrong settle count shows up at the `busy` port as a pulse of the wrong length, visible as soon as the first conversion ends. A stale freshness bit shows up as a wrong under-run flag, and so as a wrong `irq`, right after the second DMA load. Errors in the start gating or the formatting show up on `dac_code` two cycles after the triggering access. Errors in the flag priorities show up on the status readback in the cycle after the conflicting write.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

    localparam int BUS_W  = 32;
    localparam int HOLD_W = 16;
    localparam int CODE_W = 12;
    localparam int BYTE_W = 8;
    localparam int PAD_W  = CODE_W - BYTE_W;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_SWTRG = 8'h04;
    localparam logic [7:0] OFS_HOLD  = 8'h08;
    localparam logic [7:0] OFS_CODE  = 8'h0C;
    localparam logic [7:0] OFS_STAT  = 8'h10;
    localparam logic [7:0] OFS_TIME  = 8'h14;

    localparam int STAT_BUSY_BIT = 8;

    typedef enum logic [1:0] {
        WID_12 = 2'b00,
        WID_8  = 2'b01,
        WID_X2 = 2'b10,
        WID_X3 = 2'b11
    } width_e;

    typedef struct packed {
        width_e width;
        logic   lalign;
        logic   trgen;
        logic   urien;
        logic   dmaen;
        logic   ien;
        logic   en;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [BUS_W-1:0] w);
        ctrl_t c;
        c.en     = w[0];
        c.ien    = w[1];
        c.dmaen  = w[2];
        c.urien  = w[3];
        c.trgen  = w[4];
        c.lalign = w[10];
        c.width  = width_e'(w[15:14]);
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_pack(input ctrl_t c);
        logic [BUS_W-1:0] r;
        r        = '0;
        r[0]     = c.en;
        r[1]     = c.ien;
        r[2]     = c.dmaen;
        r[3]     = c.urien;
        r[4]     = c.trgen;
        r[10]    = c.lalign;
        r[15:14] = c.width;
        return r;
    endfunction

    // Widths other than the 8-bit code behave as 12-bit.
    function automatic logic [CODE_W-1:0] align_code(input logic [HOLD_W-1:0] h,
                                                     input logic lalign,
                                                     input width_e wid);
        if (wid == WID_8)
            return lalign ? {h[HOLD_W-1 -: BYTE_W], {PAD_W{1'b0}}}
                          : {h[BYTE_W-1:0], {PAD_W{1'b0}}};
        return lalign ? h[HOLD_W-1 -: CODE_W] : h[CODE_W-1:0];
    endfunction

endpackage

// File: rtl/dacseq_format.sv
module dacseq_format
    import dacseq_pkg::*;
(
    input  logic [HOLD_W-1:0] hold,
    input  ctrl_t             ctrl,
    output logic [CODE_W-1:0] code
);
    always_comb code = align_code(hold, ctrl.lalign, ctrl.width);
endmodule

// File: rtl/dacseq_timer.sv
module dacseq_timer #(
    parameter int SETTLE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SETTLE_W-1:0] settle,
    output logic                busy,
    output logic                done
);
    logic [SETTLE_W-1:0] cnt_q;

    assign done = busy && (cnt_q >= settle);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end else if (done) begin
            busy  <= 1'b0;
        end else if (busy) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_cnt_zero_on_start_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> cnt_q == '0);
endmodule

// File: rtl/dacseq_ctrl.sv
module dacseq_ctrl
    import dacseq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int SETTLE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              trig_in,
    output logic [11:0]       dac_code,
    output logic              busy,
    output logic              irq,
    output logic              dma_req
);
    ctrl_t               ctrl_q;
    logic [HOLD_W-1:0]   hold_q;
    logic [CODE_W-1:0]   code_q;
    logic [SETTLE_W-1:0] settle_q;
    logic                fin_q, udr_q, fresh_q, start_q, dma_q;
    logic                done, load;
    logic [CODE_W-1:0]   fmt_code;

    logic wr_hit;
    logic wr_ctrl, wr_swtrg, wr_hold, wr_stat, wr_time;
    logic start_req;

    assign wr_hit   = bus_sel && bus_wr;
    assign wr_ctrl  = wr_hit && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_swtrg = wr_hit && (bus_addr == ADDR_W'(OFS_SWTRG));
    assign wr_hold  = wr_hit && (bus_addr == ADDR_W'(OFS_HOLD));
    assign wr_stat  = wr_hit && (bus_addr == ADDR_W'(OFS_STAT));
    assign wr_time  = wr_hit && (bus_addr == ADDR_W'(OFS_TIME));

    // Start source chosen by trigger mode; registered one cycle.
    assign start_req = ctrl_q.trgen ? (trig_in || (wr_swtrg && bus_wdata[0])) : wr_hold;
    assign load      = start_q && ctrl_q.en && !busy;

    dacseq_format u_fmt (
        .hold (hold_q),
        .ctrl (ctrl_q),
        .code (fmt_code)
    );

    dacseq_timer #(.SETTLE_W(SETTLE_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .settle (settle_q),
        .busy   (busy),
        .done   (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            hold_q   <= '0;
            code_q   <= '0;
            settle_q <= '0;
            fin_q    <= 1'b0;
            udr_q    <= 1'b0;
            fresh_q  <= 1'b0;
            start_q  <= 1'b0;
            dma_q    <= 1'b0;
        end else begin
            start_q <= start_req;
            dma_q   <= load && ctrl_q.dmaen;
            if (wr_ctrl) ctrl_q   <= ctrl_unpack(bus_wdata);
            if (wr_hold) hold_q   <= bus_wdata[HOLD_W-1:0];
            if (wr_time) settle_q <= bus_wdata[SETTLE_W-1:0];
            if (load)    code_q   <= fmt_code;

            // Hardware set wins over a simultaneous write-1-to-clear.
            if (done)                         fin_q <= 1'b1;
            else if (load)                    fin_q <= 1'b0;
            else if (wr_stat && bus_wdata[0]) fin_q <= 1'b0;

            if (load && ctrl_q.dmaen && !fresh_q) udr_q <= 1'b1;
            else if (wr_stat && bus_wdata[1])     udr_q <= 1'b0;

            // A holding write in the load cycle stays pending for the next load.
            if (wr_hold)   fresh_q <= 1'b1;
            else if (load) fresh_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL): bus_rdata = ctrl_pack(ctrl_q);
            ADDR_W'(OFS_HOLD): bus_rdata[HOLD_W-1:0] = hold_q;
            ADDR_W'(OFS_CODE): bus_rdata[CODE_W-1:0] = code_q;
            ADDR_W'(OFS_STAT): begin
                bus_rdata[0]             = fin_q;
                bus_rdata[1]             = udr_q;
                bus_rdata[STAT_BUSY_BIT] = busy;
            end
            ADDR_W'(OFS_TIME): bus_rdata[SETTLE_W-1:0] = settle_q;
            default:           bus_rdata = '0;
        endcase
    end

    assign dac_code = code_q;
    assign dma_req  = dma_q;
    assign irq      = (fin_q && ctrl_q.ien) || (udr_q && ctrl_q.urien);

    p_code_only_on_load_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(dac_code));
    p_finish_at_end_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> fin_q);
    p_start_needs_enable_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ctrl_q.en));
    p_dma_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        dma_req |=> !dma_req);
    p_underrun_dma_only_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(udr_q) |-> $past(ctrl_q.dmaen));
endmodule

// File: tb/dacseq_ctrl_test.sv
module dacseq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        trig_in = 1'b0;
    logic [11:0] dac_code;
    logic        busy, irq, dma_req;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dacseq_ctrl uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_in(trig_in), .dac_code(dac_code), .busy(busy), .irq(irq),
        .dma_req(dma_req)
    );

    // {control word, holding word, expected code}
    localparam logic [43:0] VEC [8] = '{
        {16'h0001, 16'hABCD, 12'hBCD}, {16'h0401, 16'hABCD, 12'hABC},
        {16'h4001, 16'hABCD, 12'hCD0}, {16'h4401, 16'hABCD, 12'hAB0},
        {16'h0001, 16'h5F3A, 12'hF3A}, {16'h0401, 16'h5F3A, 12'h5F3},
        {16'h4001, 16'h5F3A, 12'h3A0}, {16'h4401, 16'h5F3A, 12'h5F0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk); trig_in = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    endtask

    logic [31:0] v;
    int n;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, v); check("R1 ctrl", v, 0);
        rd(8'h10, v); check("R1 status", v, 0);
        rd(8'h0C, v); check("R1 code reg", v, 0);
        check("R1 ports", {busy, irq, dma_req, dac_code}, 0);

        // R6 formatting table
        wr(8'h14, 0);
        for (int i = 0; i < 8; i++) begin
            wr(8'h00, {16'h0, VEC[i][43:28]});
            wr(8'h08, {16'h0, VEC[i][27:12]});
            idle(4);
            rd(8'h0C, v); check("R6 format reg", v, {20'h0, VEC[i][11:0]});
            check("R6 format port", {20'h0, dac_code}, {20'h0, VEC[i][11:0]});
        end

        // R11 control readback mask
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R11 ctrl mask", v, 32'h0000_C41F);

        // R2/R3 direct start and settle length
        wr(8'h00, 32'h1);
        wr(8'h14, 32'd5);
        rd(8'h14, v); check("R3 timing readback", v, 5);
        wr(8'h08, 32'h0123);
        @(negedge clk);
        n = 0;
        for (int i = 0; i < 3000 && busy; i++) begin n++; @(negedge clk); end
        check("R3 busy cycles", n, 6);
        rd(8'h10, v); check("R3 finish after settle", v, 32'h1);
        check("R2 code port", {20'h0, dac_code}, 32'h123);
        wr(8'h0C, 32'hFFF);
        rd(8'h0C, v); check("R2 code reg write ignored", v, 32'h123);

        // R7 finish cleared by a new start, then by W1C
        wr(8'h08, 32'h0456);
        rd(8'h10, v); check("R7 start clears finish", v, 32'h100);
        wait_idle();
        rd(8'h10, v); check("R7 finish set again", v, 32'h1);
        wr(8'h10, 32'h1);
        rd(8'h10, v); check("R7 w1c finish", v, 0);

        // R8 interrupt gating
        wr(8'h00, 32'h3);
        wr(8'h08, 32'h0789);
        idle(1); wait_idle(); idle(1);
        check("R8 irq on finish", irq, 1);
        wr(8'h10, 32'h1);
        check("R8 irq cleared", irq, 0);
        wr(8'h00, 32'h1);
        wr(8'h08, 32'h0789);
        idle(1); wait_idle(); idle(1);
        check("R8 irq masked", irq, 0);

        // R5 ignored while busy, and while disabled
        wr(8'h14, 32'd20);
        wr(8'h08, 32'h0111);
        idle(1);
        check("R5 busy started", busy, 1);
        wr(8'h08, 32'h0222);
        wait_idle(); idle(4);
        check("R5 no deferred start", busy, 0);
        check("R5 busy start ignored", {20'h0, dac_code}, 32'h111);
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h0333);
        idle(4);
        check("R5 disabled no busy", busy, 0);
        check("R5 disabled code", {20'h0, dac_code}, 32'h111);

        // R4 trigger mode
        wr(8'h14, 32'd0);
        wr(8'h00, 32'h11);
        wr(8'h08, 32'h0444);
        idle(4);
        check("R4 hold write no start", {20'h0, dac_code}, 32'h111);
        rd(8'h04, v); check("R4 swtrg reads 0", v, 0);
        pulse_trig(); idle(3);
        check("R4 trig_in start", {20'h0, dac_code}, 32'h444);
        wr(8'h08, 32'h0555);
        wr(8'h04, 32'h1); idle(3);
        check("R4 sw trigger start", {20'h0, dac_code}, 32'h555);
        wr(8'h08, 32'h0666);
        wr(8'h04, 32'h0); idle(3);
        check("R4 sw write of 0", {20'h0, dac_code}, 32'h555);

        // R9/R10 DMA mode with under-run
        wr(8'h10, 32'h3);
        wr(8'h00, 32'h1D);
        pulse_trig();
        @(negedge clk); check("R9 dma_req pulse", dma_req, 1);
        @(negedge clk); check("R9 dma_req one cycle", dma_req, 0);
        rd(8'h10, v); check("R10 no underrun when fresh", v & 32'h2, 0);
        check("R10 fresh data loaded", {20'h0, dac_code}, 32'h666);
        pulse_trig(); idle(3);
        rd(8'h10, v); check("R10 underrun flag", v & 32'h2, 32'h2);
        check("R10 old data reused", {20'h0, dac_code}, 32'h666);
        check("R8 irq on underrun", irq, 1);
        wr(8'h10, 32'h2);
        rd(8'h10, v); check("R10 w1c underrun", v & 32'h2, 0);
        check("R8 irq after underrun clear", irq, 0);
        wr(8'h00, 32'h11);
        pulse_trig(); idle(3);
        pulse_trig(); idle(3);
        rd(8'h10, v); check("R10 no underrun without dma", v & 32'h2, 0);
        check("R9 no dma_req without dma", dma_req, 0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule